// File: doc/BRIEF.md
# Temperature Monitor Alert Controller

This block sits between an on-die temperature sensor front end and a simple host register port. Software starts the sensor, selects temperature-monitoring mode and programs a repeat setting for continuous conversion. Each conversion arrives as a 9-bit two's-complement sample, one LSB per degree, with a one-cycle valid strobe. The block keeps the most recent accepted sample in a readable result register.

Three alert channels compare every accepted sample against their own 8-bit signed limit. When a channel is armed and a sample is strictly above its limit, the channel latches a status flag. The flag holds until software writes its clear bit. A single interrupt line, registered once, reports any latched flag whose interrupt enable is set. All three channels' enable, status and clear bits share one control word at a 4-bit stride.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The run register (offset 0x00) holds bit 0. The mode register (0x04) holds bits 3:0. The repeat register (0x08) holds an endless flag in bit 24 and a period code in bits 3:0. Every other bit of these registers reads 0.
- R3: The result register (0x0C) returns the last accepted sample in bits 8:0, with all higher bits 0. A sample is accepted when `sample_valid` is 1, run is 1 and mode equals 0x5. Otherwise the result register keeps its value.
- R4: The limit register of channel n sits at 0x10 + 4n, for n = 0..2. It holds the signed limit in bits 23:16 and the channel arm bit in bit 0. Every other bit reads 0.
- R5: The status flag of channel n sets when a sample is accepted, the channel is armed, and the signed sample is strictly greater than the sign-extended limit.
- R6: A set status flag stays set through later samples below the limit.
- R7: In the interrupt control word (0x20), channel n uses bit 4n as interrupt enable, bit 4n+1 as status and bit 4n+2 as clear. Writing 1 to bit 4n+2 resets that status flag. The clear bit always reads 0. Writes to bit 4n+1 have no effect.
- R8: When a clear write and a triggering sample for the same channel land in the same cycle, the status flag ends up set.
- R9: `irq` equals the OR over channels of (status AND interrupt enable), delayed by one clock.
- R10: No status flag sets while run is 0, while the mode is not 0x5, or while the channel is not armed.
- R11: Reads from any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sample_valid | input | 1 | One-cycle strobe for a new conversion |
| sample_data | input | 9 | Signed conversion result in degrees |
| irq | output | 1 | Registered combined alert interrupt |

## Verification
The hardest case to reach from the ports is a clear write and a triggering sample landing in the same clock. The bench creates it by driving a clear write and a valid over-limit sample on the same falling edge, so that one rising edge captures both. It then reads the status back.

The compare boundary is covered by a sweep of all 512 sample values against each channel. Each channel is tested with limits at both signed extremes, at -1 and 0, and at a mid value. The bench clears all status flags before every vector and recomputes the expected flag arithmetically.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned TAC_DW        = 32;
  localparam int unsigned OFS_RUN       = 'h00;
  localparam int unsigned OFS_MODE      = 'h04;
  localparam int unsigned OFS_RPT       = 'h08;
  localparam int unsigned OFS_TEMP      = 'h0C;
  localparam int unsigned OFS_LIM_BASE  = 'h10;
  localparam int unsigned OFS_LIM_STEP  = 4;
  localparam int unsigned OFS_IRQCTL    = 'h20;
  localparam int unsigned IRQ_STRIDE    = 4;
  localparam int unsigned LIM_LSB       = 16;
  localparam int unsigned RPT_END_BIT   = 24;
  localparam logic [3:0]  MODE_MONITOR  = 4'h5;
endpackage

// File: rtl/tac_sensor_ctl.sv
module tac_sensor_ctl
  import tac_pkg::*;
#(
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned PER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_run,
  input  logic              wr_mode,
  input  logic              wr_rpt,
  input  logic              run_wdata,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              endless_wdata,
  input  logic [PER_W-1:0]  per_wdata,
  input  logic              sample_valid,
  input  logic [TEMP_W-1:0] sample_data,
  output logic              run_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              endless_q,
  output logic [PER_W-1:0]  per_q,
  output logic [TEMP_W-1:0] temp_q,
  output logic              active,
  output logic              capture
);
  logic              run_d, endless_d;
  logic [MODE_W-1:0] mode_d;
  logic [PER_W-1:0]  per_d;
  logic [TEMP_W-1:0] temp_d;

  assign active  = run_q && (mode_q == MODE_W'(MODE_MONITOR));
  assign capture = active && sample_valid;

  always_comb begin
    run_d     = wr_run  ? run_wdata     : run_q;
    mode_d    = wr_mode ? mode_wdata    : mode_q;
    endless_d = wr_rpt  ? endless_wdata : endless_q;
    per_d     = wr_rpt  ? per_wdata     : per_q;
    temp_d    = capture ? sample_data   : temp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      mode_q    <= '0;
      endless_q <= 1'b0;
      per_q     <= '0;
      temp_q    <= '0;
    end else begin
      run_q     <= run_d;
      mode_q    <= mode_d;
      endless_q <= endless_d;
      per_q     <= per_d;
      temp_q    <= temp_d;
    end
  end
endmodule

// File: rtl/tac_alert_chan.sv
module tac_alert_chan #(
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned LIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lim,
  input  logic              wr_ctl,
  input  logic [LIM_W-1:0]  lim_wdata,
  input  logic              arm_wdata,
  input  logic              ie_wdata,
  input  logic              clr_wdata,
  input  logic              capture,
  input  logic [TEMP_W-1:0] sample_data,
  output logic [LIM_W-1:0]  lim_q,
  output logic              arm_q,
  output logic              ie_q,
  output logic              status_q
);
  localparam int unsigned EXT_W = TEMP_W - LIM_W;

  logic [LIM_W-1:0]  lim_d;
  logic              arm_d, ie_d, status_d, trigger;
  logic [TEMP_W-1:0] lim_ext;

  assign lim_ext = {{EXT_W{lim_q[LIM_W-1]}}, lim_q};
  assign trigger = capture && arm_q && ($signed(sample_data) > $signed(lim_ext));

  always_comb begin
    lim_d = wr_lim ? lim_wdata : lim_q;
    arm_d = wr_lim ? arm_wdata : arm_q;
    ie_d  = wr_ctl ? ie_wdata  : ie_q;
    if (trigger)
      status_d = 1'b1;
    else if (wr_ctl && clr_wdata)
      status_d = 1'b0;
    else
      status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q    <= '0;
      arm_q    <= 1'b0;
      ie_q     <= 1'b0;
      status_q <= 1'b0;
    end else begin
      lim_q    <= lim_d;
      arm_q    <= arm_d;
      ie_q     <= ie_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import tac_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sample_valid,
  input  logic [TEMP_W-1:0] sample_data,
  output logic              irq
);
  localparam int unsigned MODE_W = 4;
  localparam int unsigned PER_W  = 4;

  logic              run_q, endless_q, active, capture;
  logic [MODE_W-1:0] mode_q;
  logic [PER_W-1:0]  per_q;
  logic [TEMP_W-1:0] temp_q;
  logic              wr_irqctl;
  logic [N_CH-1:0]   arm_vec, ie_vec, status_vec;
  logic [N_CH-1:0][LIM_W-1:0] lim_vec;
  logic              irq_d, irq_q;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_irqctl    = bus_wr && (bus_addr == ADDR_W'(OFS_IRQCTL));

  tac_sensor_ctl #(.TEMP_W(TEMP_W), .MODE_W(MODE_W), .PER_W(PER_W)) u_sensor (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_run        (bus_wr && (bus_addr == ADDR_W'(OFS_RUN))),
    .wr_mode       (bus_wr && (bus_addr == ADDR_W'(OFS_MODE))),
    .wr_rpt        (bus_wr && (bus_addr == ADDR_W'(OFS_RPT))),
    .run_wdata     (bus_wdata[0]),
    .mode_wdata    (bus_wdata[MODE_W-1:0]),
    .endless_wdata (bus_wdata[RPT_END_BIT]),
    .per_wdata     (bus_wdata[PER_W-1:0]),
    .sample_valid  (sample_valid),
    .sample_data   (sample_data),
    .run_q         (run_q),
    .mode_q        (mode_q),
    .endless_q     (endless_q),
    .per_q         (per_q),
    .temp_q        (temp_q),
    .active        (active),
    .capture       (capture)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tac_alert_chan #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_lim      (bus_wr && (bus_addr == ADDR_W'(OFS_LIM_BASE + OFS_LIM_STEP*c))),
      .wr_ctl      (wr_irqctl),
      .lim_wdata   (bus_wdata[LIM_LSB +: LIM_W]),
      .arm_wdata   (bus_wdata[0]),
      .ie_wdata    (bus_wdata[IRQ_STRIDE*c]),
      .clr_wdata   (bus_wdata[IRQ_STRIDE*c+2]),
      .capture     (capture),
      .sample_data (sample_data),
      .lim_q       (lim_vec[c]),
      .arm_q       (arm_vec[c]),
      .ie_q        (ie_vec[c]),
      .status_q    (status_vec[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_RUN))  bus_rdata[0] = run_q;
    if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata[MODE_W-1:0] = mode_q;
    if (bus_addr == ADDR_W'(OFS_RPT)) begin
      bus_rdata[RPT_END_BIT] = endless_q;
      bus_rdata[PER_W-1:0]   = per_q;
    end
    if (bus_addr == ADDR_W'(OFS_TEMP)) bus_rdata[TEMP_W-1:0] = temp_q;
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr == ADDR_W'(OFS_LIM_BASE + OFS_LIM_STEP*c)) begin
        bus_rdata[LIM_LSB +: LIM_W] = lim_vec[c];
        bus_rdata[0]                = arm_vec[c];
      end
      if (bus_addr == ADDR_W'(OFS_IRQCTL)) begin
        bus_rdata[IRQ_STRIDE*c]   = ie_vec[c];
        bus_rdata[IRQ_STRIDE*c+1] = status_vec[c];
      end
    end
  end

  assign irq_d = |(status_vec & ie_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tac_checker.sv
module tac_checker
  import tac_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sample_valid,
  input logic              irq,
  input logic              active,
  input logic [TEMP_W-1:0] temp_q,
  input logic [N_CH-1:0]   status_vec,
  input logic [N_CH-1:0]   ie_vec
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_IRQCTL));

  p_temp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && sample_valid) |=> $stable(temp_q));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(status_vec & ie_vec)));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_vec & ie_vec)) |=> irq);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      status_vec[c] && !(ctl_wr && bus_wdata[IRQ_STRIDE*c+2]) |=> status_vec[c]);

    p_status_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_vec[c]) |-> $past(active && sample_valid));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && bus_wdata[IRQ_STRIDE*c+2] && !sample_valid |=> !status_vec[c]);
  end
endmodule

bind thermal_alert_ctrl tac_checker #(.N_CH(N_CH), .TEMP_W(TEMP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .sample_valid (sample_valid),
  .irq          (irq),
  .active       (active),
  .temp_q       (temp_q),
  .status_vec   (status_vec),
  .ie_vec       (ie_vec)
);

// File: tb/thermal_alert_ctrl_tb.sv
module thermal_alert_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sample_valid = 1'b0;
  logic [8:0]  sample_data = '0;
  logic        irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_alert_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_valid(sample_valid),
    .sample_data(sample_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic smp(input int v);
    @(negedge clk);
    sample_valid = 1'b1; sample_data = 9'(v);
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  function automatic logic [31:0] limw(input int v);
    return {8'h00, 8'(v), 15'h0, 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    int lims [5] = '{-128, -1, 0, 57, 127};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 'h28; a += 4) begin
      rd(8'(a), d); check("R1 reset read", d, 32'h0);
    end
    check("R1 irq low", {31'h0, irq}, 32'h0);
    // R2 control fields
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 run", d, 32'h1);
    wr(8'h04, 32'hFFFF_FFF7); rd(8'h04, d); check("R2 mode", d, 32'h7);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2 repeat", d, 32'h0100_000F);
    // R4 limit fields
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); check("R4 limit fields", d, 32'h00FF_0001);
    wr(8'h14, 32'h0);
    // R11 unmapped
    rd(8'h1C, d); check("R11 unmapped 1C", d, 32'h0);
    rd(8'h24, d); check("R11 unmapped 24", d, 32'h0);
    // R10 mode not monitor: no capture, no trigger
    wr(8'h10, limw(0));
    smp(100);
    rd(8'h0C, d); check("R10 mode off temp held", d, 32'h0);
    rd(8'h20, d); check("R10 mode off no status", d, 32'h0);
    // R10 run off
    wr(8'h04, 32'h5); wr(8'h00, 32'h0);
    smp(100);
    rd(8'h20, d); check("R10 run off no status", d, 32'h0);
    rd(8'h0C, d); check("R3 run off temp held", d, 32'h0);
    // R10 channel not armed, temp still captured (R3)
    wr(8'h00, 32'h1); wr(8'h10, 32'h0);
    smp(100);
    rd(8'h20, d); check("R10 unarmed no status", d, 32'h0);
    rd(8'h0C, d); check("R3 capture", d, 32'd100);
    // R5 / R3 sweep
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 3; k++) wr(8'(16 + 4*k), 32'h0);
      foreach (lims[li]) begin
        wr(8'(16 + 4*c), limw(lims[li]));
        for (int s = -256; s < 256; s++) begin
          wr(8'h20, 32'h444);
          smp(s);
          rd(8'h20, d);
          check($sformatf("R5 ch%0d lim %0d smp %0d", c, lims[li], s), d,
                (s > lims[li]) ? (32'h1 << (4*c+1)) : 32'h0);
          rd(8'h0C, d);
          check("R3 temp sweep", d, {23'h0, 9'(s)});
        end
      end
    end
    for (int k = 0; k < 3; k++) wr(8'(16 + 4*k), 32'h0);
    // R7 status bit not writable, clear reads 0
    wr(8'h20, 32'h777);
    rd(8'h20, d); check("R7 status read-only", d, 32'h111);
    wr(8'h20, 32'h0);
    // R9 irq timing
    wr(8'h10, limw(10));
    wr(8'h20, 32'h1);
    smp(20);
    check("R9 irq one cycle later (not yet)", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq asserted", {31'h0, irq}, 32'h1);
    // R6 sticky
    smp(-50);
    rd(8'h20, d); check("R6 sticky", d, 32'h3);
    // R8 trigger beats clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h5;
    sample_valid = 1'b1; sample_data = 9'd20;
    @(negedge clk);
    bus_wr = 1'b0; sample_valid = 1'b0;
    rd(8'h20, d); check("R8 trigger wins", d, 32'h3);
    // R7 clear
    wr(8'h20, 32'h5);
    rd(8'h20, d); check("R7 clear", d, 32'h1);
    @(negedge clk);
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    // R9 irq follows enable removal
    smp(20);
    @(negedge clk);
    check("R9 irq on", {31'h0, irq}, 32'h1);
    wr(8'h20, 32'h0);
    @(negedge clk);
    check("R9 irq off after disable", {31'h0, irq}, 32'h0);
    rd(8'h20, d); check("R7 status kept without enable", d, 32'h2);
    report();
  end
endmodule